// File: doc/BRIEF.md
# Serial Programming Command Interface

This block is the slave end of a two-wire programming port. An external master toggles a programming clock and uses one bidirectional data line. Every transaction has a fixed frame. The frame starts with a 4-bit command and is followed by a 16-bit payload. Bits travel least significant first. The slave samples input bits on the falling edge of the programming clock. For read-type commands, the slave takes over the data line once the command field is complete. It then presents one payload bit per clock, changing the line on each rising edge, so the master can capture the bit on the following falling edge.

The programming clock and the data line are brought into the system clock domain through synchronisers, and all logic runs on the system clock. At the end of each recognised frame, the command and its payload are presented to the nonvolatile write controller as a valid pulse lasting one cycle. The block keeps a 16-bit table latch, which one command loads and another reads back. A status command shifts out a word supplied by the write controller. The master starts a write by sending a payload that sets the start bit, then sends the status command repeatedly until bit 0 reads back as 0.

If the programming clock stops toggling for longer than a configurable number of system cycles, any partially received frame is thrown away.

Top module: `pgm_serial_port`

## Requirements
- R1: After reset, `pgm_dat_oe` is 0, `cmd_valid_o` is 0 and `latch_o` is 0.
- R2: A frame is 4 command bits followed by 16 payload bits, each LSB first and each sampled on a falling edge of `pgm_clk_i`. Command 4'h0 (core instruction, write type) produces `cmd_code_o`=4'h0 and `cmd_data_o` equal to the received payload.
- R3: `cmd_valid_o` is high for exactly one system clock per recognised frame.
- R4: Command 4'hD (write latch) copies its payload into `latch_o`. `latch_o` changes at no other time.
- R5: Command 4'h2 (read latch) drives `pgm_dat_oe`=1 from the falling edge that ends the command field until the last falling edge of the frame. On each of the 16 payload rising edges, `pgm_dat_o` takes the next bit of the latch, LSB first. `cmd_data_o` reports the word that was shifted out.
- R6: Command 4'h9 (read status) shifts out `status_i` in the same way as R5, sampled when the command field completes. The master polls bit 0 (the start bit) through this command until it reads as 0.
- R7: Codes other than 4'h0, 4'h2, 4'h9 and 4'hD still consume a full 16-bit payload. They raise no valid pulse, leave `latch_o` unchanged and never assert `pgm_dat_oe`.
- R8: If `pgm_clk_i` has no edge for IDLE_LIMIT system cycles, the frame position returns to zero and a partial frame is discarded.
- R9: `pgm_dat_oe` is 0 throughout the command field and throughout every write-type frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgm_clk_i | input | 1 | External programming clock |
| pgm_dat_i | input | 1 | Data line as seen at the pin |
| pgm_dat_o | output | 1 | Data driven onto the line during reads |
| pgm_dat_oe | output | 1 | Output enable for the data line |
| status_i | input | 16 | Status word from the write controller (bit 0 = start/busy) |
| cmd_valid_o | output | 1 | One-cycle pulse per recognised frame |
| cmd_code_o | output | 4 | Command of the completed frame |
| cmd_data_o | output | 16 | Payload received, or word shifted out |
| latch_o | output | 16 | Table latch contents |

## Verification
The assertions assume that the programming clock is slow compared with the system clock. Each clock level must last longer than the synchroniser delay, so that every edge is seen exactly once. They also assume that the master holds each data bit steady around the falling edge that samples it. The bench keeps each clock level at eight system cycles and changes data only on rising edges, while the clock is high. It sweeps all sixteen command codes with several payloads, uses a command-to-payload gap well inside the idle limit, and exercises a stall longer than that limit only on purpose.

// File: rtl/pgm_serial_pkg.sv
package pgm_serial_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_CORE_INSTR = 4'h0;
    localparam logic [CMD_W-1:0] CMD_RD_LATCH   = 4'h2;
    localparam logic [CMD_W-1:0] CMD_RD_STATUS  = 4'h9;
    localparam logic [CMD_W-1:0] CMD_WR_LATCH   = 4'hD;

    function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
        return (c == CMD_RD_LATCH) || (c == CMD_RD_STATUS);
    endfunction

    function automatic logic cmd_is_known(input logic [CMD_W-1:0] c);
        return (c == CMD_CORE_INSTR) || (c == CMD_WR_LATCH) || cmd_is_read(c);
    endfunction

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pgm_idle_timer.sv
module pgm_idle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity_i,
    output logic idle_hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (activity_i) begin
            count_d = '0;
        end else if (count_q != CW'(LIMIT)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign idle_hit_o = !activity_i && (count_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pgm_serial_port.sv
module pgm_serial_port
    import pgm_serial_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_clk_i,
    input  logic              pgm_dat_i,
    output logic              pgm_dat_o,
    output logic              pgm_dat_oe,
    input  logic [DATA_W-1:0] status_i,
    output logic              cmd_valid_o,
    output logic [CMD_W-1:0]  cmd_code_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic [DATA_W-1:0] latch_o
);
    localparam int FRAME_BITS = CMD_W + DATA_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] POS_CMD_LAST   = POS_W'(CMD_W - 1);
    localparam logic [POS_W-1:0] POS_FRAME_LAST = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic              clk_prev;
        logic [POS_W-1:0]  pos;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] tx_word;
        logic              oe;
        logic              dout;
        logic [DATA_W-1:0] latch;
        logic              valid;
        logic [CMD_W-1:0]  vcode;
        logic [DATA_W-1:0] vdata;
    } state_t;

    state_t st_d, st_q;

    logic [1:0] sync_w;
    logic       pclk_s, pdat_s;
    logic       rise_w, fall_w, idle_hit_w;

    pgm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({pgm_dat_i, pgm_clk_i}),
        .sync_o (sync_w)
    );
    assign pclk_s = sync_w[0];
    assign pdat_s = sync_w[1];

    assign rise_w = pclk_s && !st_q.clk_prev;
    assign fall_w = !pclk_s && st_q.clk_prev;

    pgm_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .activity_i(rise_w || fall_w),
        .idle_hit_o(idle_hit_w)
    );

    logic [CMD_W-1:0]  cmd_next;
    logic [DATA_W-1:0] rx_next;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = pclk_s;
        st_d.valid    = 1'b0;
        cmd_next      = {pdat_s, st_q.cmd[CMD_W-1:1]};
        rx_next       = {pdat_s, st_q.rx[DATA_W-1:1]};

        if (idle_hit_w) begin
            st_d.pos = '0;
            st_d.oe  = 1'b0;
        end else if (rise_w) begin
            if (st_q.oe && (st_q.pos > POS_CMD_LAST)) begin
                st_d.dout = st_q.tx[0];
                st_d.tx   = {1'b0, st_q.tx[DATA_W-1:1]};
            end
        end else if (fall_w) begin
            if (st_q.pos <= POS_CMD_LAST) begin
                st_d.cmd = cmd_next;
                st_d.pos = st_q.pos + 1'b1;
                if (st_q.pos == POS_CMD_LAST && cmd_is_read(cmd_next)) begin
                    st_d.oe      = 1'b1;
                    st_d.dout    = 1'b0;
                    st_d.tx      = (cmd_next == CMD_RD_LATCH) ? st_q.latch : status_i;
                    st_d.tx_word = st_d.tx;
                end
            end else if (st_q.pos == POS_FRAME_LAST) begin
                st_d.rx    = rx_next;
                st_d.pos   = '0;
                st_d.oe    = 1'b0;
                st_d.valid = cmd_is_known(st_q.cmd);
                if (cmd_is_known(st_q.cmd)) begin
                    st_d.vcode = st_q.cmd;
                    st_d.vdata = cmd_is_read(st_q.cmd) ? st_q.tx_word : rx_next;
                end
                if (st_q.cmd == CMD_WR_LATCH) begin
                    st_d.latch = rx_next;
                end
            end else begin
                st_d.rx  = rx_next;
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pgm_dat_o   = st_q.dout;
    assign pgm_dat_oe  = st_q.oe;
    assign cmd_valid_o = st_q.valid;
    assign cmd_code_o  = st_q.vcode;
    assign cmd_data_o  = st_q.vdata;
    assign latch_o     = st_q.latch;

    logic [POS_W-1:0] frame_pos;
    logic             idle_hit;
    assign frame_pos = st_q.pos;
    assign idle_hit  = idle_hit_w;
endmodule

// File: rtl/pgm_serial_port_chk.sv
module pgm_serial_port_chk
    import pgm_serial_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int POS_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pgm_dat_oe,
    input logic              cmd_valid_o,
    input logic [CMD_W-1:0]  cmd_code_o,
    input logic [DATA_W-1:0] latch_o,
    input logic [POS_W-1:0]  frame_pos,
    input logic              idle_hit
);
    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    p_latch_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_o) |-> (cmd_valid_o && cmd_code_o == CMD_WR_LATCH));

    p_release_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !pgm_dat_oe);

    p_known_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_is_known(cmd_code_o));

    p_timeout_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |=> (frame_pos == '0));

    p_no_drive_in_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pos < POS_W'(CMD_W)) |-> !pgm_dat_oe);
endmodule

bind pgm_serial_port pgm_serial_port_chk #(
    .DATA_W(DATA_W),
    .POS_W (POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pgm_dat_oe (pgm_dat_oe),
    .cmd_valid_o(cmd_valid_o),
    .cmd_code_o (cmd_code_o),
    .latch_o    (latch_o),
    .frame_pos  (frame_pos),
    .idle_hit   (idle_hit)
);

// File: tb/pgm_serial_port_test.sv
module pgm_serial_port_test;
    localparam int HP   = 8;
    localparam int IDLE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk = 1'b0;
    logic        pdat = 1'b0;
    logic        dat_o, dat_oe;
    logic [15:0] status;
    logic        valid;
    logic [3:0]  code;
    logic [15:0] data, latch;

    int tests = 0;
    int fails = 0;

    int          pulses = 0;
    logic [3:0]  last_code;
    logic [15:0] last_data;
    logic        oe_seen = 1'b0;

    always #2.5 clk = ~clk;

    pgm_serial_port #(.IDLE_LIMIT(IDLE)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgm_clk_i  (pclk),
        .pgm_dat_i  (pdat),
        .pgm_dat_o  (dat_o),
        .pgm_dat_oe (dat_oe),
        .status_i   (status),
        .cmd_valid_o(valid),
        .cmd_code_o (code),
        .cmd_data_o (data),
        .latch_o    (latch)
    );

    always @(negedge clk) begin
        if (valid) begin
            pulses    <= pulses + 1;
            last_code <= code;
            last_data <= data;
        end
        if (dat_oe) oe_seen <= 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [19:0] bits);
        for (int i = 0; i < n; i++) begin
            pclk = 1'b1;
            pdat = bits[i];
            wait_cyc(HP);
            pclk = 1'b0;
            wait_cyc(HP);
        end
    endtask

    // full frame; rd collects bits the slave presented before each falling edge
    task automatic frame(input logic [3:0] c, input logic [15:0] p, output logic [15:0] rd,
                         output logic oe_in_cmd);
        oe_in_cmd = 1'b0;
        rd = '0;
        for (int i = 0; i < 20; i++) begin
            pclk = 1'b1;
            pdat = (i < 4) ? c[i] : p[i-4];
            wait_cyc(HP);
            if (i >= 4) rd[i-4] = dat_o;
            if (i < 4 && dat_oe) oe_in_cmd = 1'b1;
            pclk = 1'b0;
            wait_cyc(HP);
            if (i == 3) wait_cyc(12);
        end
        wait_cyc(8);
    endtask

    function automatic logic known(input logic [3:0] c);
        return c == 4'h0 || c == 4'h2 || c == 4'h9 || c == 4'hD;
    endfunction

    initial begin
        #200000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd, exp_latch, pay;
        logic        oic;
        int          p0, polls;
        status = 16'h0000;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 oe", {31'd0, dat_oe}, 0);
        check("R1 valid", {31'd0, valid}, 0);
        check("R1 latch", {16'd0, latch}, 0);

        exp_latch = 16'h0000;
        // sweep all codes with several payloads
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 4; k++) begin
                pay = 16'h1234 * (c + 1) ^ (16'h5A0F << k);
                status = ~pay;
                p0 = pulses;
                oe_seen = 1'b0;
                frame(c[3:0], pay, rd, oic);
                check("R9 cmd field", {31'd0, oic}, 0);
                if (!known(c[3:0])) begin
                    check("R7 no pulse", pulses - p0, 0);
                    check("R7 no oe", {31'd0, oe_seen}, 0);
                    check("R7 latch kept", {16'd0, latch}, {16'd0, exp_latch});
                end else begin
                    check("R3 one pulse", pulses - p0, 1);
                    check("R2 code", {28'd0, last_code}, c);
                    if (c == 2) begin
                        check("R5 shifted", {16'd0, rd}, {16'd0, exp_latch});
                        check("R5 report", {16'd0, last_data}, {16'd0, exp_latch});
                        check("R5 oe used", {31'd0, oe_seen}, 1);
                    end else if (c == 9) begin
                        check("R6 shifted", {16'd0, rd}, {16'd0, ~pay});
                        check("R6 report", {16'd0, last_data}, {16'd0, ~pay});
                    end else begin
                        check("R2 payload", {16'd0, last_data}, {16'd0, pay});
                        check("R9 write no oe", {31'd0, oe_seen}, 0);
                        if (c == 13) exp_latch = pay;
                        check("R4 latch", {16'd0, latch}, {16'd0, exp_latch});
                    end
                end
                check("R5 released", {31'd0, dat_oe}, 0);
            end
        end

        // polling the start bit
        polls = 0;
        status = 16'hBEE1;
        do begin
            if (polls == 3) status = 16'hBEE0;
            frame(4'h9, 16'h0000, rd, oic);
            polls++;
        end while (rd[0] && polls < 10);
        check("R6 poll count", polls, 4);
        check("R6 poll word", {16'd0, rd}, 32'hBEE0);

        // partial frame then stall beyond idle limit
        p0 = pulses;
        send_bits(2, 20'h0000D);
        wait_cyc(IDLE + 40);
        frame(4'h0, 16'hC3A5, rd, oic);
        check("R8 one pulse", pulses - p0, 1);
        check("R8 code", {28'd0, last_code}, 0);
        check("R8 payload", {16'd0, last_data}, 32'hC3A5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule